// File: doc/BRIEF.md
# Odd-Ones Double-Zero Recognizer

This block watches a serial stream of single bits. It keeps two facts about the bits accepted since the last reset. The first is whether an odd or an even number of ones has arrived. The second is whether two zeros have ever arrived back to back. Its output `z_out` is high exactly when the ones count is odd and a double zero has been seen. The output is a decode of the present state only, so it changes just after a clock edge and never in response to the current input bit.

Bits arrive as a valid/ready stream. A bit is consumed on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low only while the synchronous reset is asserted. Outside reset the block takes one bit every cycle and never applies back-pressure. A cycle with `in_valid` low leaves the state untouched. The six states are held in a 3-bit register. Once the double-zero condition is reached, it can only be cleared by reset.

Top module: `odd_ones_zz_detect`

## Requirements
- R1: A clock edge with `rst` high puts the machine in its start state: even ones count, no zero pending, no double zero. `z_out` is then 0.
- R2: `z_out` is 1 exactly when the accepted ones count is odd and a double zero has been seen. It is a function of the state alone and changes only after a clock edge.
- R3: An accepted 1 flips the ones-count parity.
- R4: An accepted 0 leaves the parity unchanged. A first 0 marks a zero as pending, and a second consecutive 0 completes the double zero.
- R5: An accepted 1 that follows a single pending 0, before the double zero is complete, cancels the pending zero. A later 0 then counts as a first zero again.
- R6: Once the double zero is complete, it stays set through any further bits until a reset. After that point only the parity moves `z_out`.
- R7: A cycle with `in_valid` low changes neither the state nor `z_out`.
- R8: `in_ready` is 0 while `rst` is high and 1 otherwise. There is no other back-pressure.
- R9: Starting from reset, the bits 1,1,0,0,1,1,0,1 make `z_out` high after the fifth and eighth bits and low after each of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is present |
| in_ready | output | 1 | Block accepts a bit this cycle |
| in_bit | input | 1 | Serial data bit |
| z_out | output | 1 | Odd ones and double zero seen |

## Verification
The worked sequence from reset pins down the combined behaviour. Runs of ones with no zeros show that parity alone never raises the output. A 0,1,0 pattern separates a machine that cancels a pending zero from one that keeps it. Long mixed runs after a double zero show that the flag is sticky and that parity alone then drives the output. Idle cycles with `in_valid` low are placed between bits in different states, and a mid-stream reset is applied, to show that a stalled bit is ignored and that reset returns the machine to its start state.

// File: rtl/ozd_pkg.sv
package ozd_pkg;
  localparam int STATE_W = 3;
  // bit 0 = ones parity, bits 2:1 = zero progress (0 none, 1 pending, 2 double)
  typedef enum logic [STATE_W-1:0] {
    S_E0 = 3'b000,
    S_O0 = 3'b001,
    S_E1 = 3'b010,
    S_O1 = 3'b011,
    S_E2 = 3'b100,
    S_O2 = 3'b101
  } ozd_state_t;
endpackage

// File: rtl/ozd_next.sv
module ozd_next
  import ozd_pkg::*;
(
  input  ozd_state_t cur,
  input  logic       take,
  input  logic       bit_in,
  output ozd_state_t nxt
);
  always_comb begin
    nxt = cur;
    if (take) begin
      unique case (cur)
        S_E0:    nxt = bit_in ? S_O0 : S_E1;
        S_O0:    nxt = bit_in ? S_E0 : S_O1;
        S_E1:    nxt = bit_in ? S_O0 : S_E2;
        S_O1:    nxt = bit_in ? S_E0 : S_O2;
        S_E2:    nxt = bit_in ? S_O2 : S_E2;
        S_O2:    nxt = bit_in ? S_E2 : S_O2;
        default: nxt = S_E0;
      endcase
    end
  end
endmodule

// File: rtl/ozd_state_reg.sv
module ozd_state_reg
  import ozd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ozd_state_t nxt,
  output ozd_state_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= S_E0;
    else     cur <= nxt;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (cur == S_E0));
endmodule

// File: rtl/ozd_out.sv
module ozd_out
  import ozd_pkg::*;
(
  input  ozd_state_t cur,
  output logic       z
);
  assign z = (cur == S_O2);
endmodule

// File: rtl/odd_ones_zz_detect.sv
module odd_ones_zz_detect
  import ozd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic z_out
);
  ozd_state_t cur;
  ozd_state_t nxt;
  logic       take;

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;

  ozd_next u_next (.cur(cur), .take(take), .bit_in(in_bit), .nxt(nxt));
  ozd_state_reg u_reg (.clk(clk), .rst(rst), .nxt(nxt), .cur(cur));
  ozd_out u_out (.cur(cur), .z(z_out));

  // R3
  one_flips_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bit) |=> (cur[0] != $past(cur[0])));
  // R4
  zero_keeps_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_bit) |=> (cur[0] == $past(cur[0])));
  // R5
  pending_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bit && cur[2:1] == 2'd1) |=> (cur[2:1] == 2'd0));
  // R6
  double_zero_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cur[2:1] == 2'd2) |=> (cur[2:1] == 2'd2));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cur));
endmodule

// File: tb/tb_odd_ones_zz_detect.sv
module tb_odd_ones_zz_detect;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic z_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  logic       m_par = 1'b0;
  int         m_stg = 0;

  always #(CLK_P/2) clk = ~clk;

  odd_ones_zz_detect dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .z_out(z_out)
  );

  // driver: applies one cycle of stimulus and queues the expectation
  task automatic step(input logic r, input logic v, input logic b, input string tag);
    @(negedge clk);
    rst = r; in_valid = v; in_bit = b;
    if (r) begin
      m_par = 1'b0; m_stg = 0;
    end else if (v) begin
      if (b) begin
        m_par = ~m_par;
        if (m_stg == 1) m_stg = 0;
      end else if (m_stg < 2) begin
        m_stg = m_stg + 1;
      end
    end
    q_exp.push_back({(m_par && m_stg == 2), ~r});
    q_tag.push_back(tag);
  endtask

  task automatic feed(input logic b, input string tag);
    step(1'b0, 1'b1, b, tag);
  endtask

  // monitor: compares after each edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (z_out !== e[1]) begin
        errors++;
        $display("FAIL %s z_out actual %b expected %b", t, z_out, e[1]);
      end
      checks++;
      if (in_ready !== e[0]) begin
        errors++;
        $display("FAIL R8 (%s) in_ready actual %b expected %b", t, in_ready, e[0]);
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b1, "R1");
    // R9 worked sequence
    feed(1'b1, "R9"); feed(1'b1, "R9"); feed(1'b0, "R9"); feed(1'b0, "R9");
    feed(1'b1, "R9"); feed(1'b1, "R9"); feed(1'b0, "R9"); feed(1'b1, "R9");
    // R7 idle cycles while output high, R6 sticky flag under mixed bits
    step(1'b0, 1'b0, 1'b0, "R7"); step(1'b0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 12; i++) feed(((i * 7) % 3) == 0, "R6");
    // R1 mid-stream reset, then R3 ones only never raise z
    step(1'b1, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 5; i++) feed(1'b1, "R3");
    // R5 pending zero cancelled by a one
    step(1'b1, 1'b0, 1'b0, "R1");
    feed(1'b1, "R5"); feed(1'b0, "R5"); feed(1'b1, "R5");
    feed(1'b0, "R5"); feed(1'b1, "R5"); feed(1'b1, "R5");
    // R4 zeros keep parity, then complete the double zero with odd parity
    feed(1'b1, "R3");
    step(1'b0, 1'b0, 1'b0, "R7");
    feed(1'b0, "R4");
    step(1'b0, 1'b0, 1'b1, "R7");
    feed(1'b0, "R4"); feed(1'b0, "R4");
    feed(1'b1, "R2"); feed(1'b1, "R2"); feed(1'b0, "R2");
    // R7 idle while pending zero is held
    step(1'b1, 1'b0, 1'b0, "R1");
    feed(1'b0, "R4");
    step(1'b0, 1'b0, 1'b1, "R7");
    feed(1'b1, "R5");
    feed(1'b0, "R4");
    step(1'b0, 1'b0, 1'b0, "R7");
    feed(1'b0, "R4");
    feed(1'b1, "R2");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule